// File: doc/BRIEF.md
# DRAM Row Access Sequencer

This block drives one DRAM bank through the life of a row. It takes read and write requests, each carrying a row and a column address. To serve them it steps the bank through separate phases. First the bit lines are precharged with the sense amplifier off. Next the chosen word line is raised on its own. Last the sense amplifier is switched on. The row then stays open, so later requests to the same row go straight to a one-cycle column access. A request to a different row waits until the open row has had time to restore its cells. The row is then closed in strict order: the word line drops first, the amplifier turns off next, and precharge returns last. Only after that does the new row open.

A write never touches the cells directly. During the column cycle it forces the selected column of the latched row to the new value. When the force is released, the amplifier keeps holding that value, and the whole latched row is written back into the cells while the word line stays up. A behavioural cell array is part of the block. It holds the cells and the amplifier latch, so read data is real.

The length of each phase is set by a parameter. Requests use a valid/ready handshake. Completion is a one-cycle `done` pulse. For a read, `rd_valid` is raised in the same cycle.

Top module: `dram_row_seq`

## Requirements
- R1: While reset is held and right after it, the bank is closed: `pre_en`=1, `wl_en`=`sa_en`=`col_sel`=`wr_force`=0, `req_ready`=1, `done`=`rd_valid`=0.
- R2: Opening a row from the closed state takes the following steps after the accepting edge. First, `pre_en` stays alone for T_PRE cycles. Second, `wl_en` is high alone for T_ACT cycles. Third, `wl_en` and `sa_en` are both high for T_SENSE cycles. Then the column cycle follows. `pre_en` and `wl_en` are never high together.
- R3: When a row is open, a request to that row gives a column cycle (`col_sel`=1, with `wl_en` and `sa_en` high) in the very next cycle. No precharge or activate phase comes before it.
- R4: Before any write, a read returns the reset content of the cell. That content is ((row << COL_W) | col) XOR 0xA5, cut to DATA_W bits.
- R5: A write raises `wr_force` together with `col_sel` for one cycle. It changes only the addressed column, and later reads of other columns in the row return their old values.
- R6: A row closes in this order. First, `wl_en` drops while `sa_en` stays high for one cycle. Next, one cycle has all strobes low. Then `pre_en` rises, and the T_PRE phase of the next row begins.
- R7: `wl_en` falls only after at least T_RESTORE+1 cycles, counted from the end of the sense phase, in which `wl_en` and `sa_en` were both high. If a different-row request comes early, the row is held open until that count is met.
- R8: `req_ready` is 1 only when the bank is closed and idle, or when a row is open and no request is in progress. `done` is a one-cycle pulse in the cycle after the column cycle. `rd_valid` pulses with `done` for reads only.
- R9: A written value is stored in the cells. After its row has been closed and opened again, a read returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| done | output | 1 | Request completed pulse |
| pre_en | output | 1 | Bit-line precharge enable |
| wl_en | output | 1 | Word-line enable |
| sa_en | output | 1 | Sense-amplifier enable |
| col_sel | output | 1 | Column select strobe |
| wr_force | output | 1 | Force the selected amplifier to write data |

## Verification
Some rules hold on every clock, and the assertions check them there. They are the strobe ordering rules: precharge and word line are never high together; the amplifier turns on only after the word line; on close, the word line falls before the amplifier and precharge comes back last. They also cover column strobes only inside an open row, the restore count before the word line falls, and single-cycle `done` pulses. Other behaviour only the bench scenarios can show. That includes the exact length of each phase and the data read back. It also includes the difference between an open-row hit and a miss, and how long an early miss is held. Writes that persist across a close and reopen, and neighbour columns left unchanged by a write, are scenario checks too.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_SENSE, ST_ACCESS,
    ST_OPEN, ST_DRAIN, ST_WLOFF, ST_SAOFF
  } seq_state_t;

  // Reset content of a cell: row and column concatenated, XOR 0xA5.
  function automatic logic [31:0] init_word(int r, int c, int col_w);
    return ((32'(r) << col_w) | 32'(c)) ^ 32'h0000_00A5;
  endfunction

  // Down-counter load value for a phase of len cycles.
  function automatic int unsigned phase_load(int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction

  // Restore window reached once the counter hits the limit.
  function automatic logic restore_met(int unsigned cnt, int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/restore_timer.sv
module restore_timer #(
  parameter int T_RESTORE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic restore_ok
);
  import seq_pkg::*;
  localparam int RW = $clog2(T_RESTORE + 1);
  localparam logic [RW-1:0] LIM = RW'(T_RESTORE);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (clear)                cnt <= '0;
    else if (tick && cnt != LIM)   cnt <= cnt + 1'b1;
  end

  assign restore_ok = restore_met(int'(cnt), T_RESTORE);
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wl_en,
  input  logic              sa_en,
  input  logic              col_sel,
  input  logic              wr_force,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import seq_pkg::*;
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [DATA_W-1:0] mem   [ROWS][COLS];
  logic [DATA_W-1:0] latch [COLS];
  logic              sa_prev;
  logic              sense_edge;
  logic              holding;

  assign sense_edge = sa_en && !sa_prev && wl_en;
  assign holding    = sa_en && wl_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa_prev <= 1'b0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c] <= DATA_W'(init_word(r, c, COL_W));
      for (int c = 0; c < COLS; c++) latch[c] <= '0;
    end else begin
      sa_prev <= sa_en;
      if (sense_edge) begin
        latch <= mem[row];
      end else if (holding) begin
        mem[row] <= latch;
        if (col_sel && wr_force) latch[col] <= wdata;
      end
    end
  end

  assign rdata = latch[col];
endmodule

// File: rtl/row_fsm.sv
module row_fsm #(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 8,
  parameter int T_PRE   = 2,
  parameter int T_ACT   = 3,
  parameter int T_SENSE = 2,
  parameter int CW      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              restore_ok,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val,
  output logic              rst_clear,
  output logic              rst_tick,
  output logic [ROW_W-1:0]  act_row,
  output logic [COL_W-1:0]  cur_col,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              pre_en,
  output logic              wl_en,
  output logic              sa_en,
  output logic              col_sel,
  output logic              wr_force,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);
  import seq_pkg::*;

  seq_state_t state, nxt;
  logic [ROW_W-1:0] pend_row;
  logic             pend_wr;
  logic             fire;
  logic             row_hit;

  assign fire    = req_valid && req_ready;
  assign row_hit = (req_row == act_row);

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE:   if (fire) begin
                   nxt = ST_PRE; tmr_load = 1'b1; tmr_val = CW'(phase_load(T_PRE));
                 end
      ST_PRE:    if (tmr_expired) begin
                   nxt = ST_ACT; tmr_load = 1'b1; tmr_val = CW'(phase_load(T_ACT));
                 end
      ST_ACT:    if (tmr_expired) begin
                   nxt = ST_SENSE; tmr_load = 1'b1; tmr_val = CW'(phase_load(T_SENSE));
                 end
      ST_SENSE:  if (tmr_expired) nxt = ST_ACCESS;
      ST_ACCESS: nxt = ST_OPEN;
      ST_OPEN:   if (fire) nxt = row_hit ? ST_ACCESS : ST_DRAIN;
      ST_DRAIN:  if (restore_ok) nxt = ST_WLOFF;
      ST_WLOFF:  nxt = ST_SAOFF;
      ST_SAOFF:  begin
                   nxt = ST_PRE; tmr_load = 1'b1; tmr_val = CW'(phase_load(T_PRE));
                 end
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_row  <= '0;
      cur_col   <= '0;
      cur_wdata <= '0;
      pend_wr   <= 1'b0;
      act_row   <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= nxt;
      if (fire) begin
        pend_row  <= req_row;
        cur_col   <= req_col;
        cur_wdata <= req_wdata;
        pend_wr   <= req_write;
      end
      if (state == ST_PRE) act_row <= pend_row;
      done     <= (state == ST_ACCESS);
      rd_valid <= (state == ST_ACCESS) && !pend_wr;
      if (state == ST_ACCESS && !pend_wr) rd_data <= arr_rdata;
    end
  end

  assign req_ready = (state == ST_IDLE) || (state == ST_OPEN);
  assign pre_en    = (state == ST_IDLE) || (state == ST_PRE);
  assign wl_en     = (state == ST_ACT) || (state == ST_SENSE) || (state == ST_ACCESS) ||
                     (state == ST_OPEN) || (state == ST_DRAIN);
  assign sa_en     = (state == ST_SENSE) || (state == ST_ACCESS) || (state == ST_OPEN) ||
                     (state == ST_DRAIN) || (state == ST_WLOFF);
  assign col_sel   = (state == ST_ACCESS);
  assign wr_force  = (state == ST_ACCESS) && pend_wr;
  assign rst_clear = (state == ST_SENSE);
  assign rst_tick  = (state == ST_ACCESS) || (state == ST_OPEN) || (state == ST_DRAIN);

  assert_pre_wl_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_en && wl_en));
  assert_sa_after_wl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sa_en) |-> $past(wl_en));
  assert_col_in_open_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_sel |-> (wl_en && sa_en));
  assert_wl_before_sa_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_en) |-> sa_en);
  assert_sa_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sa_en) |-> (!wl_en && !pre_en));
  assert_pre_after_sa_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_en) |-> ($past(!sa_en) && !wl_en));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rdv_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq #(
  parameter int ROW_W     = 3,
  parameter int COL_W     = 3,
  parameter int DATA_W    = 8,
  parameter int T_PRE     = 2,
  parameter int T_ACT     = 3,
  parameter int T_SENSE   = 2,
  parameter int T_RESTORE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              pre_en,
  output logic              wl_en,
  output logic              sa_en,
  output logic              col_sel,
  output logic              wr_force
);
  localparam int TMAX1 = (T_PRE > T_ACT) ? T_PRE : T_ACT;
  localparam int TMAX  = (TMAX1 > T_SENSE) ? TMAX1 : T_SENSE;
  localparam int CW    = $clog2(TMAX + 1);

  logic              tmr_load, tmr_expired;
  logic [CW-1:0]     tmr_val;
  logic              rst_clear, rst_tick, restore_ok;
  logic [ROW_W-1:0]  act_row;
  logic [COL_W-1:0]  cur_col;
  logic [DATA_W-1:0] cur_wdata, arr_rdata;

  row_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_PRE(T_PRE), .T_ACT(T_ACT), .T_SENSE(T_SENSE), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
    .req_col(req_col), .req_wdata(req_wdata), .req_ready(req_ready),
    .arr_rdata(arr_rdata), .restore_ok(restore_ok),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .rst_clear(rst_clear), .rst_tick(rst_tick),
    .act_row(act_row), .cur_col(cur_col), .cur_wdata(cur_wdata),
    .pre_en(pre_en), .wl_en(wl_en), .sa_en(sa_en),
    .col_sel(col_sel), .wr_force(wr_force),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
  );

  phase_timer #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  restore_timer #(.T_RESTORE(T_RESTORE)) u_restore (
    .clk(clk), .rst_n(rst_n), .clear(rst_clear), .tick(rst_tick),
    .restore_ok(restore_ok)
  );

  cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wl_en(wl_en), .sa_en(sa_en),
    .col_sel(col_sel), .wr_force(wr_force), .row(act_row), .col(cur_col),
    .wdata(cur_wdata), .rdata(arr_rdata)
  );

  assert_restore_before_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_en) |-> $past(restore_ok));
endmodule

// File: tb/tb_dram_row_seq.sv
module tb_dram_row_seq;
  localparam int TP = 2, TA = 3, TS = 2, TR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_row = '0, req_col = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, done, pre_en, wl_en, sa_en, col_sel, wr_force;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  dram_row_seq #(.T_PRE(TP), .T_ACT(TA), .T_SENSE(TS), .T_RESTORE(TR)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .pre_en(pre_en), .wl_en(wl_en), .sa_en(sa_en), .col_sel(col_sel),
    .wr_force(wr_force)
  );

  // kind: 0 open phase, 1 sense, 2 column, 3 done, 4 held open, 5 close, 6 resting
  typedef struct packed {
    logic [4:0] v;
    logic       rdy;
    logic       dn;
    logic       rv;
    logic [7:0] d;
    logic [2:0] kind;
    logic [3:0] idx;
  } exp_t;

  exp_t q[$];
  logic [7:0] mm [8][8];
  bit   open_m = 0;
  int   open_row = 0;
  int   since_sense = 0;
  bit   exp_ready;
  int   total = 0, fails = 0;

  localparam int NREQ = 13;
  bit    op_w [NREQ];
  int    r_row[NREQ], r_col[NREQ], r_gap[NREQ];
  logic [7:0] r_wd[NREQ];
  string r_tag[NREQ];

  function automatic string kind_tag(logic [2:0] k);
    case (k)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R3";
      3'd3:       return "R8";
      3'd4:       return "R7";
      3'd5:       return "R6";
      default:    return "R1";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(logic [4:0] v, logic rdy, logic [2:0] k);
    exp_t e;
    e = '0; e.v = v; e.rdy = rdy; e.kind = k;
    return e;
  endfunction

  task automatic push_open(int row);
    for (int i = 0; i < TP; i++) q.push_back(mk(5'b10000, 1'b0, 3'd0));
    for (int i = 0; i < TA; i++) q.push_back(mk(5'b01000, 1'b0, 3'd0));
    for (int i = 0; i < TS; i++) q.push_back(mk(5'b01100, 1'b0, 3'd1));
    open_m = 1; open_row = row;
  endtask

  task automatic push_req(int i);
    exp_t e;
    int hold;
    if (!open_m) push_open(r_row[i]);
    else if (r_row[i] != open_row) begin
      hold = TR + 1 - since_sense;
      if (hold < 1) hold = 1;
      for (int k = 0; k < hold; k++) q.push_back(mk(5'b01100, 1'b0, 3'd4));
      q.push_back(mk(5'b00100, 1'b0, 3'd5));
      q.push_back(mk(5'b00000, 1'b0, 3'd5));
      push_open(r_row[i]);
    end
    q.push_back(mk({4'b0111, op_w[i]}, 1'b0, 3'd2));
    e = mk(5'b01100, 1'b1, 3'd3);
    e.dn = 1'b1; e.rv = !op_w[i]; e.d = mm[r_row[i]][r_col[i]]; e.idx = 4'(i);
    q.push_back(e);
    if (op_w[i]) mm[r_row[i]][r_col[i]] = r_wd[i];
  endtask

  task automatic cycle_check();
    exp_t e;
    logic [7:0] actv, expv;
    if (q.size() > 0) e = q.pop_front();
    else e = mk(open_m ? 5'b01100 : 5'b10000, 1'b1, 3'd6);
    actv = {pre_en, wl_en, sa_en, col_sel, wr_force, req_ready, done, rd_valid};
    expv = {e.v, e.rdy, e.dn, e.rv};
    chk(actv == expv, kind_tag(e.kind), int'(actv), int'(expv));
    if (e.rv) chk(rd_data == e.d, r_tag[e.idx], int'(rd_data), int'(e.d));
    if (e.kind == 3'd1) since_sense = 0;
    else if (e.kind == 3'd2 || e.kind == 3'd3 || e.kind == 3'd4 ||
             (e.kind == 3'd6 && open_m)) since_sense++;
    exp_ready = e.rdy;
  endtask

  task automatic set_req(int i, bit w, int row, int col, logic [7:0] wd, int gap, string tag);
    op_w[i] = w; r_row[i] = row; r_col[i] = col; r_wd[i] = wd; r_gap[i] = gap; r_tag[i] = tag;
  endtask

  initial begin
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) mm[r][c] = 8'((r * 8 + c) ^ 8'hA5);
    set_req(0,  0, 2, 1, 8'h00, 2,  "R4");
    set_req(1,  0, 2, 5, 8'h00, 0,  "R3");
    set_req(2,  1, 2, 5, 8'h3C, 0,  "R5");
    set_req(3,  0, 2, 5, 8'h00, 0,  "R5");
    set_req(4,  0, 2, 4, 8'h00, 3,  "R5");
    set_req(5,  0, 6, 0, 8'h00, 0,  "R4");
    set_req(6,  1, 1, 7, 8'hE1, 0,  "R7");
    set_req(7,  0, 1, 6, 8'h00, 0,  "R5");
    set_req(8,  0, 1, 7, 8'h00, 0,  "R5");
    set_req(9,  0, 2, 5, 8'h00, 10, "R9");
    set_req(10, 0, 1, 7, 8'h00, 0,  "R9");
    set_req(11, 1, 1, 0, 8'h77, 0,  "R5");
    set_req(12, 0, 1, 0, 8'h00, 0,  "R5");

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held during reset
    chk({pre_en, wl_en, sa_en, col_sel, wr_force, req_ready, done, rd_valid} == 8'b10000100,
        "R1", int'({pre_en, wl_en, sa_en, col_sel, wr_force, req_ready, done, rd_valid}), 8'h84);
    rst_n = 1'b1;

    for (int i = 0; i < NREQ; i++) begin
      int g;
      bit issued;
      g = r_gap[i];
      issued = 0;
      while (!issued) begin
        @(negedge clk);
        req_valid = 1'b0;
        cycle_check();
        if (g > 0) g--;
        else if (exp_ready) begin
          req_valid = 1'b1; req_write = op_w[i];
          req_row = 3'(r_row[i]); req_col = 3'(r_col[i]); req_wdata = r_wd[i];
          push_req(i);
          issued = 1;
        end
      end
    end
    repeat (30) begin
      @(negedge clk);
      req_valid = 1'b0;
      cycle_check();
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule